// File: doc/BRIEF.md
# Edge/Level GPIO Interrupt Unit

This unit watches 32 general-purpose input pins and turns activity on them into interrupt requests. Every pin is configured on its own: level detection with a selectable active level, or edge detection with independent rising and falling enables. An edge-mode pin can either latch its event until software clears it or report it only for the clock in which it occurs. Pending events live in write-one-to-clear status registers. They are qualified by per-pin enable bits and merged into a single cascaded interrupt line.

Software reaches the unit through a simple 16-bit register bus with a byte address. Each 32-bit per-pin quantity is split into a low word (pins 0 to 15) and a high word (pins 16 to 31) two bytes above it. The unit also presents the number of the lowest-numbered enabled pending pin, and a valid flag that lets a handler recognise a request with no source behind it.

Top module: `gpio_irq_unit`

## Requirements
- R1: Registers sit at byte offsets status 0x08, enable 0x0C, edge-mode 0x10, active-level 0x14, hold 0x18, falling-enable 0x20, rising-enable 0x24, each holding pins 0-15 in bits 15:0; the word at offset+2 holds pins 16-31. Every offset except status reads back what was last written, reads of any other offset return 0, and writes there change nothing.
- R2: After reset every register reads 0 (all pins in level mode, active low, disabled), and irq_out and src_valid are low.
- R3: Pin inputs pass through a two-flop synchroniser; in level mode (edge-mode bit 0) a status bit is 1 in the cycle after the synchronised pin equals its active-level bit (1 = active high) and 0 otherwise, so a pin change shows in status three clocks later.
- R4: In edge mode (edge-mode bit 1) an event is a synchronised 0-to-1 change when the rising-enable bit is 1, or a 1-to-0 change when the falling-enable bit is 1; with both bits 0 the pin never raises an event.
- R5: An edge-mode pin with its hold bit 1 keeps its status bit set until it is cleared; with hold 0 the status bit is high for exactly one clock per event. Level mode ignores the hold bit.
- R6: Writing 1 to a status bit clears it on that clock edge, and this takes priority over an event on the same edge. Writing 0 leaves the bit unchanged. A level pin that is still active sets its bit again on the following clock.
- R7: A pin is an active source when its status and enable bits are both 1. irq_out is the OR of all active sources. Clearing an enable bit masks the pin without changing its status bit.
- R8: src_valid is high when any source is active. src_id then gives the lowest-numbered active pin, so any pin in 0-15 wins over pins 16-31. src_id is 0 when src_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock inside the unit |
| pin_in | input | 32 | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address of the register word |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| irq_out | output | 1 | Cascaded interrupt request |
| src_valid | output | 1 | At least one enabled pending source exists |
| src_id | output | 5 | Lowest-numbered enabled pending pin |

## Verification
The assertions assume a well-formed bus: write strobes are driven to a known level at every clock after reset, and the address and data are stable at the sampling edge. The bench changes its inputs one nanosecond after each rising edge, so no input ever changes at the edge that samples it. The checks on latching and clearing also assume that configuration bits change only through register writes. The random phase therefore reaches the unit only through the bus and the pins, and it includes addresses outside the map as well as status writes that collide with fresh pin events.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NPIN    = 32;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 6;
  localparam int NBANK   = NPIN / REG_W;
  localparam int BANK_AW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int BANK_LSB = 1;
  localparam int ID_W    = $clog2(NPIN);

  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_ENA  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_TYPE = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_LVL  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_HOLD = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_FALL = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_RISE = 6'h24;

  typedef struct packed {
    logic [NPIN-1:0] ena;
    logic [NPIN-1:0] edge_mode;
    logic [NPIN-1:0] act_high;
    logic [NPIN-1:0] hold;
    logic [NPIN-1:0] fall_en;
    logic [NPIN-1:0] rise_en;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_cur,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign q_cur  = cur_q;
  assign q_prev = prev_q;
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NPIN-1:0]   status,
  output logic [REG_W-1:0]  rdata,
  output pin_cfg_t          cfg,
  output logic [NPIN-1:0]   clr_mask
);
  localparam logic [ADDR_W-1:0] BASE_MASK =
    ~ADDR_W'((1 << (BANK_LSB + BANK_AW)) - 1);

  logic [ADDR_W-1:0]  base;
  logic [BANK_AW-1:0] bsel;
  pin_cfg_t           cfg_q, cfg_d;
  logic [NPIN-1:0]    rd_vec;

  assign base = addr & BASE_MASK;
  assign bsel = addr[BANK_LSB +: BANK_AW];

  function automatic logic [NPIN-1:0] put_word(input logic [NPIN-1:0] old,
                                               input logic [REG_W-1:0] val,
                                               input logic [BANK_AW-1:0] b);
    logic [NPIN-1:0] r;
    r = old;
    r[b*REG_W +: REG_W] = val;
    return r;
  endfunction

  // next-state for configuration and the clear strobe
  always_comb begin
    cfg_d    = cfg_q;
    clr_mask = '0;
    if (wr_en) begin
      unique case (base)
        OFS_STAT: clr_mask          = put_word('0, wdata, bsel);
        OFS_ENA:  cfg_d.ena         = put_word(cfg_q.ena, wdata, bsel);
        OFS_TYPE: cfg_d.edge_mode   = put_word(cfg_q.edge_mode, wdata, bsel);
        OFS_LVL:  cfg_d.act_high    = put_word(cfg_q.act_high, wdata, bsel);
        OFS_HOLD: cfg_d.hold        = put_word(cfg_q.hold, wdata, bsel);
        OFS_FALL: cfg_d.fall_en     = put_word(cfg_q.fall_en, wdata, bsel);
        OFS_RISE: cfg_d.rise_en     = put_word(cfg_q.rise_en, wdata, bsel);
        default:  cfg_d             = cfg_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  // read path
  always_comb begin
    unique case (base)
      OFS_STAT: rd_vec = status;
      OFS_ENA:  rd_vec = cfg_q.ena;
      OFS_TYPE: rd_vec = cfg_q.edge_mode;
      OFS_LVL:  rd_vec = cfg_q.act_high;
      OFS_HOLD: rd_vec = cfg_q.hold;
      OFS_FALL: rd_vec = cfg_q.fall_en;
      OFS_RISE: rd_vec = cfg_q.rise_en;
      default:  rd_vec = '0;
    endcase
    rdata = rd_vec[bsel*REG_W +: REG_W];
  end

  assign cfg = cfg_q;

  AST_ENA_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_ENA) |=> (cfg_q.ena[REG_W-1:0] == $past(wdata))); // R1
  AST_ENA_HIGH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == (OFS_ENA + ADDR_W'(2))) |=> (cfg_q.ena[NPIN-1:REG_W] == $past(wdata))); // R1
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] cur,
  input  logic [NPIN-1:0] prev,
  input  pin_cfg_t        cfg,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] status
);
  logic [NPIN-1:0] status_q, status_d, hit;

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      if (cfg.edge_mode[i]) begin
        hit[i] = (cfg.rise_en[i] & cur[i] & ~prev[i]) |
                 (cfg.fall_en[i] & ~cur[i] & prev[i]);
      end else begin
        hit[i] = (cur[i] == cfg.act_high[i]);
      end
      if (clr[i]) begin
        status_d[i] = 1'b0;
      end else if (cfg.edge_mode[i] & cfg.hold[i]) begin
        status_d[i] = status_q[i] | hit[i];
      end else begin
        status_d[i] = hit[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= status_d;
    end
  end

  assign status = status_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((status_q & $past(clr)) == '0)); // R6
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q & cfg.edge_mode & cfg.hold & ~clr) & ~status_q) == '0)); // R5
  AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(cfg.edge_mode & ~cfg.rise_en & ~cfg.fall_en & ~cfg.hold)) == '0)); // R4
endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
  parameter int W = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  active,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (active[i]) idx = IW'(i);
    end
  end

  assign any = |active;

  AST_ID_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> active[idx]); // R8
  AST_ID_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((active & ((W'(1) << idx) - W'(1))) == '0)); // R8
  AST_ID_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> (idx == '0)); // R8
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq_out,
  output logic              src_valid,
  output logic [ID_W-1:0]   src_id
);
  logic [1:0]      rst_pipe;
  logic            rst_core_n;
  logic [NPIN-1:0] pin_cur, pin_prev, status, clr_mask, active;
  pin_cfg_t        cfg;
  logic            any_src;

  // asynchronous assertion, release aligned to clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  gpio_irq_sync #(.W(NPIN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .d      (pin_in),
    .q_cur  (pin_cur),
    .q_prev (pin_prev)
  );

  gpio_irq_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .status   (status),
    .rdata    (rdata),
    .cfg      (cfg),
    .clr_mask (clr_mask)
  );

  gpio_irq_detect u_det (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .cur    (pin_cur),
    .prev   (pin_prev),
    .cfg    (cfg),
    .clr    (clr_mask),
    .status (status)
  );

  assign active = status & cfg.ena;

  gpio_irq_prio #(.W(NPIN)) u_prio (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .active (active),
    .any    (any_src),
    .idx    (src_id)
  );

  assign irq_out   = any_src;
  assign src_valid = any_src;

  AST_MASK_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && addr == OFS_ENA && wdata == '0 && status[0] && cfg.edge_mode[0] && cfg.hold[0])
      |=> (status[0] && !irq_out || |active)); // R7
endmodule

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;
  localparam logic [5:0] A_STAT = 6'h08, A_ENA = 6'h0C, A_TYPE = 6'h10,
                         A_LVL = 6'h14, A_HOLD = 6'h18, A_FALL = 6'h20,
                         A_RISE = 6'h24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pins;
  logic        wr_en;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq_out, src_valid;
  logic [4:0]  src_id;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .src_valid(src_valid),
    .src_id(src_id)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] q1, q2, q3, mst, m_ena, m_typ, m_lvl, m_hold, m_fall, m_rise, nst;
  int          m_rcnt;
  bit          ev;

  function automatic logic [31:0] mput(input logic [31:0] old, input logic [15:0] v, input bit hi);
    logic [31:0] r;
    r = old;
    if (hi) r[31:16] = v; else r[15:0] = v;
    return r;
  endfunction

  function automatic logic [15:0] mread(input logic [5:0] a);
    logic [31:0] v;
    case ({a[5:2], 2'b00})
      A_STAT: v = mst;
      A_ENA:  v = m_ena;
      A_TYPE: v = m_typ;
      A_LVL:  v = m_lvl;
      A_HOLD: v = m_hold;
      A_FALL: v = m_fall;
      A_RISE: v = m_rise;
      default: v = '0;
    endcase
    return a[1] ? v[31:16] : v[15:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n || m_rcnt < 2) begin
      if (!rst_n) m_rcnt = 0; else m_rcnt = m_rcnt + 1;
      q1 = '0; q2 = '0; q3 = '0; mst = '0;
      m_ena = '0; m_typ = '0; m_lvl = '0; m_hold = '0; m_fall = '0; m_rise = '0;
    end else begin
      for (int i = 0; i < 32; i++) begin
        if (m_typ[i]) ev = (m_rise[i] && q2[i] && !q3[i]) || (m_fall[i] && !q2[i] && q3[i]);
        else          ev = (q2[i] == m_lvl[i]);
        if (wr_en && {addr[5:2], 2'b00} == A_STAT && wdata[i % 16] && (addr[1] == (i >= 16)))
          nst[i] = 1'b0;
        else if (m_typ[i] && m_hold[i]) nst[i] = mst[i] | ev;
        else nst[i] = ev;
      end
      if (wr_en) begin
        case ({addr[5:2], 2'b00})
          A_ENA:  m_ena  = mput(m_ena,  wdata, addr[1]);
          A_TYPE: m_typ  = mput(m_typ,  wdata, addr[1]);
          A_LVL:  m_lvl  = mput(m_lvl,  wdata, addr[1]);
          A_HOLD: m_hold = mput(m_hold, wdata, addr[1]);
          A_FALL: m_fall = mput(m_fall, wdata, addr[1]);
          A_RISE: m_rise = mput(m_rise, wdata, addr[1]);
          default: ;
        endcase
      end
      q3 = q2; q2 = q1; q1 = pins; mst = nst;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    logic [31:0] act;
    int          eid;
    if (rst_n === 1'b1) begin
      act = mst & m_ena;
      eid = 0;
      for (int i = 31; i >= 0; i--) if (act[i]) eid = i;
      check("R7 irq_out", {31'b0, irq_out}, {31'b0, |act});
      check("R8 src_valid", {31'b0, src_valid}, {31'b0, |act});
      check("R8 src_id", {27'b0, src_id}, eid);
      if ({addr[5:2], 2'b00} == A_STAT) check("R6 status read", {16'b0, rdata}, {16'b0, mread(addr)});
      else                              check("R1 register read", {16'b0, rdata}, {16'b0, mread(addr)});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr = a;
    @(negedge clk); d = rdata;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    logic [15:0] v;
    logic [5:0]  alist [16];
    rst_n = 1'b0; pins = '0; wr_en = 1'b0; addr = A_ENA; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);

    // R2 reset state
    check("R2 irq after reset", {31'b0, irq_out}, 0);
    check("R2 valid after reset", {31'b0, src_valid}, 0);
    rd(A_ENA, v);       check("R2 enable low", {16'b0, v}, 0);
    rd(A_TYPE + 2, v);  check("R2 type high", {16'b0, v}, 0);

    // R1 map and R3 level mode
    wr(A_LVL, 16'hFFFF); wr(A_LVL + 2, 16'hFFFF);
    idle(3);
    rd(A_STAT, v);      check("R3 idle status", {16'b0, v}, 0);
    rd(A_LVL + 2, v);   check("R1 level high readback", {16'b0, v}, 16'hFFFF);
    wr(6'h2A, 16'h1234);
    rd(6'h2A, v);       check("R1 unmapped read", {16'b0, v}, 0);

    pins[5] = 1'b1; idle(4);
    rd(A_STAT, v);      check("R3 level active", {16'b0, v}, 16'h0020);
    wr(A_ENA, 16'h0020); wr(A_ENA + 2, 16'hFFFF);
    check("R7 irq on enabled pin", {31'b0, irq_out}, 1);
    check("R8 id pin5", {27'b0, src_id}, 5);
    pins[20] = 1'b1; idle(4);
    rd(A_STAT + 2, v);  check("R3 level high bank", {16'b0, v}, 16'h0010);
    check("R8 low bank wins", {27'b0, src_id}, 5);
    wr(A_STAT, 16'h0020);
    rd(A_STAT, v);      check("R6 cleared", {16'b0, v}, 0);
    rd(A_STAT, v);      check("R6 level re-sets", {16'b0, v}, 16'h0020);
    wr(A_ENA, 16'h0000);
    check("R8 high bank when low masked", {27'b0, src_id}, 20);
    rd(A_STAT, v);      check("R7 mask keeps status", {16'b0, v}, 16'h0020);
    pins[5] = 1'b0; pins[20] = 1'b0; idle(4);
    check("R8 no source", {31'b0, src_valid}, 0);
    check("R7 no irq", {31'b0, irq_out}, 0);

    // R4/R5 edge mode
    wr(A_TYPE, 16'h0008); wr(A_RISE, 16'h0008); wr(A_HOLD, 16'h0008);
    idle(2);
    rd(A_STAT, v);      check("R4 edge idle", {16'b0, v}, 0);
    pins[3] = 1'b1; idle(4);
    rd(A_STAT, v);      check("R4 rising caught", {16'b0, v}, 16'h0008);
    idle(3);
    rd(A_STAT, v);      check("R5 held", {16'b0, v}, 16'h0008);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, v);      check("R6 zero write", {16'b0, v}, 16'h0008);
    wr(A_STAT, 16'h0008);
    rd(A_STAT, v);      check("R6 one clears", {16'b0, v}, 0);
    pins[3] = 1'b0; idle(4);
    rd(A_STAT, v);      check("R4 falling ignored", {16'b0, v}, 0);
    wr(A_FALL, 16'h0008); wr(A_RISE, 16'h0000);
    pins[3] = 1'b1; idle(4);
    rd(A_STAT, v);      check("R4 rising ignored", {16'b0, v}, 0);
    pins[3] = 1'b0; idle(4);
    rd(A_STAT, v);      check("R4 falling caught", {16'b0, v}, 16'h0008);
    wr(A_STAT, 16'h0008);
    wr(A_TYPE, 16'h0048); wr(A_RISE, 16'h0040); wr(A_FALL, 16'h0000);
    pins[6] = 1'b1; idle(4);
    rd(A_STAT, v);      check("R5 pass-through pulse gone", {16'b0, v}, 0);
    wr(A_TYPE, 16'h00C8);
    pins[7] = 1'b1; idle(4);
    rd(A_STAT, v);      check("R4 no select no event", {16'b0, v}, 0);

    // random phase, compared every clock against the model
    alist = '{A_STAT, A_STAT + 2, A_ENA, A_ENA + 2, A_TYPE, A_TYPE + 2, A_LVL, A_LVL + 2,
              A_HOLD, A_HOLD + 2, A_FALL, A_FALL + 2, A_RISE, A_RISE + 2, 6'h00, 6'h3E};
    for (int k = 0; k < 4000; k++) begin
      pins = pins ^ ($urandom & $urandom & $urandom);
      addr = alist[$urandom % 16];
      wdata = 16'($urandom);
      wr_en = ($urandom % 3 == 0);
      @(posedge clk); #1;
    end
    wr_en = 1'b0;
    idle(2);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule